// File: doc/BRIEF.md
# Upper-Lane Parity Generator and Checker for a 64-bit PCI Bus

This block handles even parity for the high half of a 64-bit PCI bus. The high half is the upper 32 address/data bits, the four upper active-low byte enables and the PAR64 parity bit. On the transmit side it places the upper lanes on the bus in any cycle in which the agent runs an address or data phase. A single-address-cycle address phase leaves the upper lanes reserved, so the block drives zeros on them there. In the following cycle it drives PAR64. PAR64 is computed so that the count of ones across the 32 bits, the four enables and PAR64 together is even.

On the receive side the block records the upper lanes every cycle, along with what kind of phase the cycle held. In the next cycle it compares the incoming PAR64 against the parity it computed. A mismatch raises a one-cycle error strobe in the cycle after PAR64 was sampled. Which strobe fires depends on the phase:
- An address phase is checked only when REQ64# was low during it.
- A data phase is checked only when it completed with IRDY# and TRDY# both low on a transfer negotiated as 64 bits wide.

Top module: `pci_hi_lane_parity`

## Requirements
- R1: Whenever `par64_oe` is high, `par64_out` makes the number of ones across that cycle's `par64_out` and the previous cycle's `ad_hi_out` and `be_hi_out_n` even.
- R2: For each cycle in which `drv_addr` or `drv_data` is high, `par64_oe` is high in the next cycle and carries that phase's parity.
- R3: A driven address phase with `drv_sac` high puts all zeros on `ad_hi_out` and `be_hi_out_n`, with `ad_hi_oe` high. The PAR64 that follows is 0.
- R4: `ad_hi_oe` is high in exactly the cycles in which `drv_addr` or `drv_data` is high. `par64_oe` stays high for one cycle after `ad_hi_oe` drops and then goes low. While not driving, `ad_hi_out` and `be_hi_out_n` read zero.
- R5: In an address phase (`rx_addr` high) with `req64_n` low, a wrong `bus_par64` in the next cycle makes `addr_perr` high for exactly one cycle, two cycles after the address phase.
- R6: An address phase with `req64_n` high never raises `addr_perr`, whatever `bus_par64` carries.
- R7: A data phase with `irdy_n` and `trdy_n` both low and `wide_ok` high, followed by a wrong `bus_par64`, makes `data_perr` high for exactly one cycle, two cycles after the phase.
- R8: A data cycle with `irdy_n` or `trdy_n` high, or with `wide_ok` low, never raises `data_perr`.
- R9: Correct parity raises no strobe. `rx_addr` takes precedence over a data completion in the same cycle, so the two strobes are never high together.
- R10: While `rst_n` is low, `par64_oe`, `par64_out`, `addr_perr` and `data_perr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_addr | input | 1 | This agent drives an address phase this cycle |
| drv_data | input | 1 | This agent drives a data phase this cycle |
| drv_sac | input | 1 | The driven address phase is single-address-cycle (upper lanes reserved) |
| drv_ad_hi | input | 32 | Upper address/data value to drive |
| drv_be_hi_n | input | 4 | Upper byte enables to drive, active low |
| ad_hi_out | output | 32 | Upper address/data lanes toward the pads |
| be_hi_out_n | output | 4 | Upper byte-enable lanes toward the pads |
| ad_hi_oe | output | 1 | Output enable of the upper lanes |
| par64_out | output | 1 | Generated PAR64 |
| par64_oe | output | 1 | Output enable of PAR64 |
| bus_ad_hi | input | 32 | Upper address/data lanes seen on the bus |
| bus_be_hi_n | input | 4 | Upper byte enables seen on the bus |
| bus_par64 | input | 1 | PAR64 seen on the bus |
| rx_addr | input | 1 | The current bus cycle is an address phase |
| req64_n | input | 1 | REQ64# as seen on the bus, active low |
| irdy_n | input | 1 | IRDY# as seen on the bus, active low |
| trdy_n | input | 1 | TRDY# as seen on the bus, active low |
| wide_ok | input | 1 | The current transfer was negotiated at 64 bits |
| addr_perr | output | 1 | One-cycle upper-lane address parity error strobe |
| data_perr | output | 1 | One-cycle upper-lane data parity error strobe |

## Verification
The hardest situations to reach from the ports are the ones where a bad PAR64 arrives but must be ignored. These are an address phase without REQ64#, a data cycle held in a wait state, and a data cycle on a 32-bit transfer. Each of them looks like an error one cycle before the strobe would appear. The stimulus task therefore takes a "corrupt" flag for every receive phase. Each qualified error case is placed next to one of these unqualified ones, so that the expected strobe and the expected silence fall in adjacent cycles.

Back-to-back driven phases with a single idle gap are used to catch the PAR64 enable release one cycle late. A same-cycle address and data completion, both corrupted, shows which phase wins.

// File: rtl/hlp_pkg.sv
package hlp_pkg;

    localparam int AD_HI_W = 32;
    localparam int BE_HI_W = 4;
    localparam int LANE_W  = AD_HI_W + BE_HI_W;

    typedef struct packed {
        logic par;
        logic oe;
    } tx_state_t;

    typedef struct packed {
        logic exp_par;
        logic chk_addr;
        logic chk_data;
        logic aperr;
        logic dperr;
    } rx_state_t;

endpackage

// File: rtl/hlp_parity.sv
module hlp_parity #(
    parameter int W = 36
) (
    input  logic [W-1:0] lanes,
    output logic         odd
);
    localparam int LEVELS = $clog2(W);
    localparam int PADW   = 1 << LEVELS;

    logic [PADW-1:0] pad;
    logic [2*PADW-2:0] node;

    always_comb begin
        pad = '0;
        pad[W-1:0] = lanes;
    end

    // balanced XOR tree: leaves at node[PADW-1 +: PADW], root at node[0]
    genvar g;
    generate
        for (g = 0; g < PADW; g++) begin : g_leaf
            assign node[PADW-1+g] = pad[g];
        end
        for (g = 0; g < PADW-1; g++) begin : g_inner
            assign node[g] = node[2*g+1] ^ node[2*g+2];
        end
    endgenerate

    assign odd = node[0];
endmodule

// File: rtl/hlp_tx.sv
module hlp_tx
    import hlp_pkg::*;
#(
    parameter int AW = AD_HI_W,
    parameter int BW = BE_HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_addr,
    input  logic          drv_data,
    input  logic          drv_sac,
    input  logic [AW-1:0] drv_ad_hi,
    input  logic [BW-1:0] drv_be_hi_n,
    output logic [AW-1:0] ad_hi_out,
    output logic [BW-1:0] be_hi_out_n,
    output logic          ad_hi_oe,
    output logic          par64_out,
    output logic          par64_oe
);
    localparam int LW = AW + BW;

    tx_state_t     st_d, st_q;
    logic [AW-1:0] ad_d;
    logic [BW-1:0] be_d;
    logic          drive_d;
    logic          odd_w;

    hlp_parity #(.W(LW)) i_gen_par (
        .lanes ({ad_d, be_d}),
        .odd   (odd_w)
    );

    always_comb begin
        drive_d = drv_addr | drv_data;
        ad_d    = '0;
        be_d    = '0;
        if (drive_d && !(drv_addr && drv_sac)) begin
            ad_d = drv_ad_hi;
            be_d = drv_be_hi_n;
        end
        st_d     = st_q;
        st_d.oe  = drive_d;
        st_d.par = drive_d ? odd_w : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ad_hi_out   = ad_d;
    assign be_hi_out_n = be_d;
    assign ad_hi_oe    = drive_d;
    assign par64_out   = st_q.par;
    assign par64_oe    = st_q.oe;

    a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
        par64_oe |-> ((^{par64_out, $past(ad_hi_out), $past(be_hi_out_n)}) == 1'b0));

    a_r2_par_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_addr || drv_data) |=> par64_oe);

    a_r3_sac_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_addr && drv_sac) |-> (ad_hi_oe && ad_hi_out == '0 && be_hi_out_n == '0));

    a_r4_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ad_hi_oe && !$past(ad_hi_oe)) |-> !par64_oe);
endmodule

// File: rtl/hlp_rx.sv
module hlp_rx
    import hlp_pkg::*;
#(
    parameter int AW = AD_HI_W,
    parameter int BW = BE_HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_ad_hi,
    input  logic [BW-1:0] bus_be_hi_n,
    input  logic          bus_par64,
    input  logic          rx_addr,
    input  logic          req64_n,
    input  logic          irdy_n,
    input  logic          trdy_n,
    input  logic          wide_ok,
    output logic          addr_perr,
    output logic          data_perr
);
    localparam int LW = AW + BW;

    rx_state_t st_d, st_q;
    logic      odd_w;
    logic      miss;

    hlp_parity #(.W(LW)) i_chk_par (
        .lanes ({bus_ad_hi, bus_be_hi_n}),
        .odd   (odd_w)
    );

    always_comb begin
        st_d          = st_q;
        // stage 1: capture lane parity and phase qualification
        st_d.exp_par  = odd_w;
        st_d.chk_addr = rx_addr & ~req64_n;
        st_d.chk_data = ~rx_addr & ~irdy_n & ~trdy_n & wide_ok;
        // stage 2: compare against PAR64 arriving one cycle later
        miss          = bus_par64 ^ st_q.exp_par;
        st_d.aperr    = st_q.chk_addr & miss;
        st_d.dperr    = st_q.chk_data & miss;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_perr = st_q.aperr;
    assign data_perr = st_q.dperr;

    a_r5_addr_needs_req64: assert property (@(posedge clk) disable iff (!rst_n)
        addr_perr |-> $past(rx_addr && !req64_n, 2));

    a_r7_data_needs_completion: assert property (@(posedge clk) disable iff (!rst_n)
        data_perr |-> $past(!irdy_n && !trdy_n && wide_ok, 2));

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_perr && data_perr));
endmodule

// File: rtl/pci_hi_lane_parity.sv
module pci_hi_lane_parity
    import hlp_pkg::*;
#(
    parameter int AW = AD_HI_W,
    parameter int BW = BE_HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_addr,
    input  logic          drv_data,
    input  logic          drv_sac,
    input  logic [AW-1:0] drv_ad_hi,
    input  logic [BW-1:0] drv_be_hi_n,
    output logic [AW-1:0] ad_hi_out,
    output logic [BW-1:0] be_hi_out_n,
    output logic          ad_hi_oe,
    output logic          par64_out,
    output logic          par64_oe,
    input  logic [AW-1:0] bus_ad_hi,
    input  logic [BW-1:0] bus_be_hi_n,
    input  logic          bus_par64,
    input  logic          rx_addr,
    input  logic          req64_n,
    input  logic          irdy_n,
    input  logic          trdy_n,
    input  logic          wide_ok,
    output logic          addr_perr,
    output logic          data_perr
);
    hlp_tx #(.AW(AW), .BW(BW)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .drv_addr    (drv_addr),
        .drv_data    (drv_data),
        .drv_sac     (drv_sac),
        .drv_ad_hi   (drv_ad_hi),
        .drv_be_hi_n (drv_be_hi_n),
        .ad_hi_out   (ad_hi_out),
        .be_hi_out_n (be_hi_out_n),
        .ad_hi_oe    (ad_hi_oe),
        .par64_out   (par64_out),
        .par64_oe    (par64_oe)
    );

    hlp_rx #(.AW(AW), .BW(BW)) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_ad_hi   (bus_ad_hi),
        .bus_be_hi_n (bus_be_hi_n),
        .bus_par64   (bus_par64),
        .rx_addr     (rx_addr),
        .req64_n     (req64_n),
        .irdy_n      (irdy_n),
        .trdy_n      (trdy_n),
        .wide_ok     (wide_ok),
        .addr_perr   (addr_perr),
        .data_perr   (data_perr)
    );

    a_r10_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!rst_n ? (!par64_oe && !par64_out && !addr_perr && !data_perr) : 1'b1));
endmodule

// File: tb/test_pci_hi_lane_parity.sv
module test_pci_hi_lane_parity;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drv_addr = 0, drv_data = 0, drv_sac = 0;
    logic [31:0] drv_ad_hi = '0;
    logic [3:0]  drv_be_hi_n = '0;
    logic [31:0] ad_hi_out;
    logic [3:0]  be_hi_out_n;
    logic        ad_hi_oe, par64_out, par64_oe;
    logic [31:0] bus_ad_hi = '0;
    logic [3:0]  bus_be_hi_n = '0;
    logic        bus_par64 = 0, rx_addr = 0, req64_n = 1, irdy_n = 1, trdy_n = 1, wide_ok = 0;
    logic        addr_perr, data_perr;

    always #2 clk = ~clk;   // 250 MHz

    pci_hi_lane_parity i_pci_hi_lane_parity (.*);

    typedef struct {
        int          cyc;
        int          sig;   // 0 ad_oe 1 ad_out 2 be_out 3 par_oe 4 par 5 aperr 6 dperr
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   tick = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    logic pend_par = 1'b0;

    always @(posedge clk) tick <= tick + 1;

    function automatic logic [31:0] actual(int s);
        case (s)
            0: return {31'b0, ad_hi_oe};
            1: return ad_hi_out;
            2: return {28'b0, be_hi_out_n};
            3: return {31'b0, par64_oe};
            4: return {31'b0, par64_out};
            5: return {31'b0, addr_perr};
            default: return {31'b0, data_perr};
        endcase
    endfunction

    task automatic push(int c, int s, logic [31:0] v, string r);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    // monitor: compares every item due in the current cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].cyc == tick) begin
                    n_vec++;
                    if (actual(q[i].sig) !== q[i].val) begin
                        n_bad++;
                        $display("FAIL %s sig%0d cyc%0d actual=%h expected=%h",
                                 q[i].req, q[i].sig, tick, actual(q[i].sig), q[i].val);
                    end
                    q.delete(i);
                end
            end
        end
    end

    // tk: 0 idle 1 addr 2 data; rk: 0 idle 1 addr 2 data
    task automatic step(int tk, logic sac, logic [31:0] tad, logic [3:0] tbe,
                        int rk, logic rq_n, logic ir_n, logic tr_n, logic wd,
                        logic [31:0] rad, logic [3:0] rbe, logic bad, string tag);
        logic [31:0] ead;
        logic [3:0]  ebe;
        logic        drv, ea, ed;
        @(negedge clk);
        drv_addr = (tk == 1); drv_data = (tk == 2); drv_sac = sac;
        drv_ad_hi = tad; drv_be_hi_n = tbe;
        bus_par64 = pend_par;
        rx_addr = (rk == 1); req64_n = rq_n; irdy_n = ir_n; trdy_n = tr_n; wide_ok = wd;
        bus_ad_hi = rad; bus_be_hi_n = rbe;
        pend_par = (^{rad, rbe}) ^ bad;
        drv = (tk != 0);
        ead = (!drv || (tk == 1 && sac)) ? 32'h0 : tad;
        ebe = (!drv || (tk == 1 && sac)) ? 4'h0 : tbe;
        push(tick, 0, {31'b0, drv}, {tag, " R4"});
        push(tick, 1, ead, {tag, (tk == 1 && sac) ? " R3" : " R4"});
        push(tick, 2, {28'b0, ebe}, {tag, (tk == 1 && sac) ? " R3" : " R4"});
        push(tick + 1, 3, {31'b0, drv}, {tag, drv ? " R2" : " R4"});
        if (drv) push(tick + 1, 4, {31'b0, ^{ead, ebe}}, {tag, " R1"});
        ea = (rk == 1) && !rq_n && bad;
        ed = (rk != 1) && !ir_n && !tr_n && wd && bad;
        push(tick + 2, 5, {31'b0, ea}, {tag, (rk == 1) ? (rq_n ? " R6" : " R5") : " R9"});
        push(tick + 2, 6, {31'b0, ed}, {tag, (rk != 1 && bad) ? (ed ? " R7" : " R8") : " R9"});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++)
            step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1, 0, 32'h0, 4'h0, 0, "idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        n_vec++;
        if ({par64_oe, par64_out, addr_perr, data_perr} !== 4'b0) begin
            n_bad++;
            $display("FAIL R10 reset outputs actual=%b expected=0000",
                     {par64_oe, par64_out, addr_perr, data_perr});
        end
        rst_n = 1'b1;
        idle(2);
        // transmit: full address, SAC address, data bursts
        step(1, 0, 32'hDEAD_BEEF, 4'hA, 0, 1, 1, 1, 0, 0, 0, 0, "tx addr");
        step(2, 0, 32'h0000_0001, 4'h0, 0, 1, 1, 1, 0, 0, 0, 0, "tx data");
        step(2, 0, 32'hFFFF_FFFF, 4'hF, 0, 1, 1, 1, 0, 0, 0, 0, "tx data");
        idle(1);
        step(1, 1, 32'h1234_5677, 4'h7, 0, 1, 1, 1, 0, 0, 0, 0, "tx sac");
        step(2, 0, 32'h8000_0000, 4'h1, 0, 1, 1, 1, 0, 0, 0, 0, "tx data");
        idle(2);
        // receive: qualified address errors next to unqualified ones
        step(0, 0, 0, 0, 1, 0, 1, 1, 0, 32'hCAFE_0001, 4'h3, 1, "rx addr bad req64");
        step(0, 0, 0, 0, 1, 1, 1, 1, 0, 32'hCAFE_0002, 4'h3, 1, "rx addr bad no-req64");
        step(0, 0, 0, 0, 1, 0, 1, 1, 0, 32'h0F0F_0F0F, 4'h5, 0, "rx addr good");
        step(0, 0, 0, 0, 2, 1, 0, 0, 1, 32'h1111_2222, 4'h0, 1, "rx data bad done");
        step(0, 0, 0, 0, 2, 1, 0, 1, 1, 32'h1111_2223, 4'h0, 1, "rx data bad wait");
        step(0, 0, 0, 0, 2, 1, 1, 0, 1, 32'h1111_2224, 4'h0, 1, "rx data bad irdy");
        step(0, 0, 0, 0, 2, 1, 0, 0, 0, 32'h1111_2225, 4'h0, 1, "rx data bad narrow");
        step(0, 0, 0, 0, 2, 1, 0, 0, 1, 32'h7777_0000, 4'hE, 0, "rx data good");
        step(0, 0, 0, 0, 2, 1, 0, 0, 1, 32'h7777_0001, 4'hE, 1, "rx data bad b2b");
        step(0, 0, 0, 0, 2, 1, 0, 0, 1, 32'h7777_0002, 4'hE, 1, "rx data bad b2b");
        step(0, 0, 0, 0, 1, 0, 0, 0, 1, 32'h5555_AAAA, 4'h9, 1, "rx addr+done bad");
        // both sides at once
        step(1, 0, 32'h0000_00FF, 4'h2, 1, 0, 1, 1, 0, 32'h3, 4'h0, 1, "mix");
        step(2, 0, 32'h0001_0000, 4'h8, 2, 1, 0, 0, 1, 32'h4, 4'h1, 0, "mix");
        idle(4);
        print_done();
    end

    task automatic print_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        print_done();
    end
endmodule